// File: doc/BRIEF.md
# Interrupt coalescing credit controller

This block governs one interrupt source. Each one-cycle assertion event on its input can turn into a one-cycle send pulse on its output. Three things decide whether it does: a holdoff countdown that restarts on every send, a mask bit that can set itself on every send, and a signed credit count that records sends until software takes them back. An event that cannot be sent at once is held as pending. It goes out in the first cycle the interrupt becomes eligible again.

Software reaches the block through a plain 32-bit register port. Reads are combinational from the address and writes take effect at the clock edge. Through this port software programs the holdoff length, the mask and the auto-mask option. It also writes a credit word that subtracts from the count in one step and can, in the same write, unmask the source and restart the countdown. The countdown moves only on cycles where the tick-enable input is high, so an outside divider sets its time base. The event input and the send output are single-cycle control pulses with no handshake. The register port has no back-pressure either: every write is accepted in the cycle it is presented.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the mask reads 1, and the holdoff length, current countdown, credit count and auto-mask option all read 0. Pending is 0 and no send is produced.
- R2: When the mask is 0 and the countdown is 0, an event produces a send in the same cycle. With a holdoff length of 0, every event is sent.
- R3: A send loads the countdown from the holdoff length at that edge. The countdown then falls by one on each edge with tick-enable high, holds when tick-enable is low, and stays at 0 without wrapping. No send occurs while it is nonzero, so with tick-enable always high and events every cycle, sends repeat every length+1 cycles.
- R4: An event that is not sent sets pending. A pending event is sent in the first cycle in which the mask is 0 and the countdown is 0. A send clears pending.
- R5: While the mask is 1, no send occurs. Writing word offset 0x04 sets the mask to bit 0 of the data.
- R6: When the auto-mask option (offset 0x0C, bit 0) is 1, every send sets the mask to 1. If a send and a mask write fall in the same cycle, the auto-mask wins.
- R7: Each send adds one to a 16-bit two's-complement credit count. The count reads in bits 15:0 of offset 0x08, and bits 31:16 read 0.
- R8: A write to offset 0x08 subtracts data bits 14:0 from the credit count at that edge. A send in the same cycle is also counted.
- R9: A credit write whose result is zero clears pending. An event in that same cycle that is not sent is still left pending.
- R10: In a credit write, data bit 16 set clears the mask and data bit 17 set reloads the countdown from the holdoff length. Both bits together re-arm the source.
- R11: The holdoff length is at offset 0x00 (6 bits, so up to 0x3F) and the current countdown reads at offset 0x10. Writes to 0x10 are ignored. Offsets 0x14 to 0x1F read 0 and ignore writes. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Countdown time base: the countdown moves only when this is high |
| evt_i | input | 1 | One-cycle interrupt assertion event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte address within the 32-byte register window |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_send_o | output | 1 | One-cycle interrupt send pulse |
| pending_o | output | 1 | An event is waiting to be sent |

## Verification
A wrong countdown shows up at the send output within one holdoff period. A sweep over every small holdoff length, with events held high, checks the exact cycle of every send, and the countdown register is read back cycle by cycle while tick-enable is toggled. A wrong pending or mask state appears as a missing or extra send in the very next eligible cycle. A wrong credit count shows up at the next credit read, either as a wrong signed value or as pending state that is cleared or kept when it should not be.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 5;
  localparam int SEL_W  = ADDR_W - 2;
  localparam int UNMASK_BIT = 16;
  localparam int RELOAD_BIT = 17;

  typedef enum logic [SEL_W-1:0] {
    SEL_HOLDOFF = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_CREDIT  = 3'd2,
    SEL_AUTOMSK = 3'd3,
    SEL_COUNT   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_holdoff,
  input  logic             wr_mask,
  input  logic             wr_automsk,
  input  logic [TMR_W-1:0] wdata_lo,
  input  logic             unmask_req,
  input  logic             send,
  output logic [TMR_W-1:0] holdoff_q,
  output logic             mask_q,
  output logic             automsk_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdoff_q <= '0;
      mask_q    <= 1'b1;
      automsk_q <= 1'b0;
    end else begin
      if (wr_holdoff) holdoff_q <= wdata_lo;
      if (wr_automsk) automsk_q <= wdata_lo[0];
      if (send && automsk_q)  mask_q <= 1'b1;
      else if (wr_mask)       mask_q <= wdata_lo[0];
      else if (unmask_req)    mask_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_holdoff_timer.sv
module irqc_holdoff_timer #(
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] count_q,
  output logic             expired
);
  assign expired = (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                     count_q <= '0;
    else if (load)                  count_q <= load_val;
    else if (tick_en && !expired)   count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/irqc_credit_track.sv
module irqc_credit_track #(
  parameter int CRED_W = 16,
  parameter int DEC_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic              evt,
  input  logic              cred_wr,
  input  logic [DEC_W-1:0]  dec_val,
  output logic [CRED_W-1:0] cred_q,
  output logic              pending_q
);
  logic [CRED_W-1:0] cred_n;
  logic              zero_clr;

  always_comb begin
    cred_n = cred_q + CRED_W'(send);
    if (cred_wr) cred_n = cred_n - CRED_W'(dec_val);
  end

  assign zero_clr = cred_wr && (cred_n == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cred_q    <= '0;
      pending_q <= 1'b0;
    end else begin
      cred_q    <= cred_n;
      pending_q <= !send && (evt || (pending_q && !zero_clr));
    end
  end
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import irqc_pkg::*;
#(
  parameter int TMR_W  = 6,
  parameter int CRED_W = 16,
  parameter int DEC_W  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en_i,
  input  logic        evt_i,
  input  logic        reg_wr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_send_o,
  output logic        pending_o
);
  reg_sel_e          sel;
  logic              wr_holdoff, wr_mask, wr_automsk, cred_wr;
  logic              unmask_req, reload_req, send;
  logic [TMR_W-1:0]  holdoff_q, count_q;
  logic              mask_q, automsk_q, expired, pending_q;
  logic [CRED_W-1:0] cred_q;
  logic              unused_bits;

  assign sel        = reg_sel_e'(reg_addr_i[ADDR_W-1:2]);
  assign wr_holdoff = reg_wr_i && (sel == SEL_HOLDOFF);
  assign wr_mask    = reg_wr_i && (sel == SEL_MASK);
  assign wr_automsk = reg_wr_i && (sel == SEL_AUTOMSK);
  assign cred_wr    = reg_wr_i && (sel == SEL_CREDIT);
  assign unmask_req = cred_wr && reg_wdata_i[UNMASK_BIT];
  assign reload_req = cred_wr && reg_wdata_i[RELOAD_BIT];
  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[31:RELOAD_BIT+1],
                         reg_wdata_i[UNMASK_BIT-1:DEC_W]};

  assign send = (evt_i || pending_q) && !mask_q && expired;

  irqc_cfg_regs #(.TMR_W(TMR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_holdoff(wr_holdoff), .wr_mask(wr_mask), .wr_automsk(wr_automsk),
    .wdata_lo(reg_wdata_i[TMR_W-1:0]), .unmask_req(unmask_req), .send(send),
    .holdoff_q(holdoff_q), .mask_q(mask_q), .automsk_q(automsk_q)
  );

  irqc_holdoff_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en_i),
    .load(send || reload_req), .load_val(holdoff_q),
    .count_q(count_q), .expired(expired)
  );

  irqc_credit_track #(.CRED_W(CRED_W), .DEC_W(DEC_W)) u_cred (
    .clk(clk), .rst_n(rst_n), .send(send), .evt(evt_i),
    .cred_wr(cred_wr), .dec_val(reg_wdata_i[DEC_W-1:0]),
    .cred_q(cred_q), .pending_q(pending_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_HOLDOFF: reg_rdata_o = 32'(holdoff_q);
      SEL_MASK:    reg_rdata_o = 32'(mask_q);
      SEL_CREDIT:  reg_rdata_o = 32'(cred_q);
      SEL_AUTOMSK: reg_rdata_o = 32'(automsk_q);
      SEL_COUNT:   reg_rdata_o = 32'(count_q);
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_send_o = send;
  assign pending_o  = pending_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int TMR_W  = 6,
  parameter int CRED_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              send,
  input logic              mask_q,
  input logic              automsk_q,
  input logic              pending_q,
  input logic              reload_req,
  input logic              cred_wr,
  input logic [TMR_W-1:0]  count_q,
  input logic [TMR_W-1:0]  holdoff_q,
  input logic [CRED_W-1:0] cred_q
);
  a_r3_quiet_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> (count_q == '0));
  a_r5_quiet_while_masked: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> !mask_q);
  a_r4_pending_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !mask_q && count_q == '0) |-> send);
  a_r4_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    send |=> !pending_q);
  a_r6_auto_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (send && automsk_q) |=> mask_q);
  a_r7_credit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !cred_wr) |=> (cred_q == CRED_W'($past(cred_q) + 1'b1)));
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (send || reload_req) |=> (count_q == $past(holdoff_q)));
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !send && !reload_req) |=> (count_q == '0));
endmodule

bind irq_coalesce_ctrl irqc_chk #(.TMR_W(TMR_W), .CRED_W(CRED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .send(send), .mask_q(mask_q),
  .automsk_q(automsk_q), .pending_q(pending_q), .reload_req(reload_req),
  .cred_wr(cred_wr), .count_q(count_q), .holdoff_q(holdoff_q), .cred_q(cred_q)
);

// File: tb/irq_coalesce_ctrl_tb.sv
`timescale 1ns/1ps
module irq_coalesce_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en_i = 1'b1;
  logic        evt_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_send_o, pending_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_cred = '0;

  always #2 clk = ~clk;

  irq_coalesce_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .evt_i(evt_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_send_o(irq_send_o), .pending_o(pending_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    reg_addr_i = a; #1;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic cyc(logic e, logic exp_send, string tag);
    evt_i = e; #1;
    check(tag, 32'(irq_send_o), 32'(exp_send));
    if (exp_send) exp_cred = exp_cred + 16'd1;
    tick();
    evt_i = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic exp_send, string tag);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; #1;
    check(tag, 32'(irq_send_o), 32'(exp_send));
    if (exp_send) exp_cred = exp_cred + 16'd1;
    if (a[4:2] == 3'd2) exp_cred = exp_cred - {1'b0, d[14:0]};
    tick();
    reg_wr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    #1;
    check("R1 send", 32'(irq_send_o), 0);
    check("R1 pending", 32'(pending_o), 0);
    rd(5'h00, 0, "R1 holdoff"); rd(5'h04, 1, "R1 mask");
    rd(5'h08, 0, "R1 credit");  rd(5'h0C, 0, "R1 automask");
    rd(5'h10, 0, "R1 count");
    // R5 masked event becomes pending (R4)
    cyc(1, 0, "R5 masked event");
    check("R4 pending set", 32'(pending_o), 1);
    wr(5'h04, 0, 0, "R5 mask write cycle");
    cyc(0, 1, "R4 pending flushed");
    check("R4 pending cleared", 32'(pending_o), 0);
    rd(5'h08, 32'(exp_cred), "R7 credit one");
    // R2 zero holdoff: every event sent
    for (int i = 0; i < 5; i++) cyc(1, 1, "R2 every event");
    rd(5'h08, 32'(exp_cred), "R7 credit six");
    // R9 zeroing write clears pending
    wr(5'h04, 1, 0, "R5 remask");
    cyc(1, 0, "R5 masked again");
    wr(5'h08, 32'(exp_cred), 0, "R8 zeroing write");
    check("R9 pending cleared", 32'(pending_o), 0);
    rd(5'h08, 0, "R8 credit zero");
    wr(5'h08, 32'h10000, 0, "R10 unmask flag");
    rd(5'h04, 0, "R10 mask cleared");
    for (int i = 0; i < 3; i++) cyc(0, 0, "R9 discarded event");
    // R8 signed count
    wr(5'h08, 1, 0, "R8 subtract below zero");
    rd(5'h08, 32'h0000FFFF, "R8 signed minus one");
    cyc(1, 1, "R2 send"); cyc(1, 1, "R2 send"); cyc(1, 1, "R2 send");
    rd(5'h08, 2, "R7 credit two");
    wr(5'h04, 1, 0, "R5 mask set");
    cyc(1, 0, "R5 masked event");
    evt_i = 1'b1;
    wr(5'h08, 2, 0, "R9 zeroing write with event");
    evt_i = 1'b0;
    check("R9 event kept pending", 32'(pending_o), 1);
    rd(5'h08, 0, "R8 credit zero again");
    wr(5'h04, 0, 0, "R5 unmask");
    cyc(0, 1, "R4 pending sent");
    // R8 send and credit write in one cycle
    evt_i = 1'b1;
    wr(5'h08, 1, 1, "R8 send with write");
    evt_i = 1'b0;
    rd(5'h08, 32'(exp_cred), "R8 both applied");
    // R3 holdoff sweep
    for (int k = 0; k < 8; k++) begin
      wr(5'h00, 32'(k), 0, "R11 holdoff write");
      for (int i = 0; i <= 3 * (k + 1); i++)
        cyc(1, (i % (k + 1)) == 0, k == 0 ? "R2 sweep" : "R3 sweep");
      rd(5'h10, 32'(k), "R3 count loaded");
      for (int j = 0; j < 10; j++) cyc(0, 0, "R3 idle");
      rd(5'h10, 0, "R3 count held at zero");
    end
    rd(5'h08, 32'(exp_cred), "R7 credit after sweep");
    wr(5'h00, 32'h3F, 0, "R11 max holdoff");
    rd(5'h00, 32'h3F, "R11 max holdoff read");
    wr(5'h00, 5, 0, "R11 holdoff five");
    // R3 tick enable gating
    tick_en_i = 1'b0;
    cyc(1, 1, "R3 first send");
    for (int i = 0; i < 6; i++) begin
      rd(5'h10, 5, "R3 held without tick");
      cyc(1, 0, "R3 blocked while counting");
    end
    check("R4 pending while counting", 32'(pending_o), 1);
    tick_en_i = 1'b1;
    for (int t = 0; t < 6; t++) begin
      rd(5'h10, 32'(5 - t), "R3 countdown");
      cyc(0, t == 5, "R4 sent at expiry");
    end
    rd(5'h10, 5, "R3 reloaded by send");
    for (int i = 0; i < 3; i++) cyc(0, 0, "R3 counting");
    rd(5'h10, 2, "R3 count two");
    wr(5'h08, 32'h20000, 0, "R10 reload flag");
    rd(5'h10, 5, "R10 timer reloaded");
    wr(5'h00, 0, 0, "R11 holdoff zero");
    for (int i = 0; i < 6; i++) cyc(0, 0, "R3 drain");
    // R6 auto mask and R10 re-arm
    wr(5'h0C, 1, 0, "R6 automask on");
    rd(5'h0C, 1, "R6 automask read");
    cyc(1, 1, "R6 send");
    rd(5'h04, 1, "R6 mask set by send");
    cyc(1, 0, "R6 blocked after auto mask");
    wr(5'h08, 32'h30000, 0, "R10 rearm write");
    cyc(0, 1, "R10 rearmed send");
    rd(5'h04, 1, "R6 masked again");
    check("R4 pending clear", 32'(pending_o), 0);
    // R11 reserved and read-only
    wr(5'h14, 32'hFFFFFFFF, 0, "R11 reserved write");
    rd(5'h14, 0, "R11 reserved 14"); rd(5'h18, 0, "R11 reserved 18");
    rd(5'h1C, 0, "R11 reserved 1C");
    wr(5'h10, 3, 0, "R11 count write");
    rd(5'h10, 0, "R11 count read-only");
    rd(5'h0B, 32'(exp_cred), "R11 low address bits ignored");
    rd(5'h08, 32'(exp_cred), "R7 flags read zero");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule